// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Stall Controller

This block is the data-hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the two source register indices of the instruction in decode. It compares them with the destinations of the two older instructions that are now in the execute stage and in the memory stage. From this it decides whether the decode instruction can enter execute on the next cycle. If it can, the block also decides where each of its two ALU operands should come from. Three sources are possible: the register file, the EX/MEM pipeline register, or the MEM/WB pipeline register.

Every producer carries a flag that says when its result becomes ready. A "late" producer, such as a load, has its result only after the memory stage. Any other producer has it after the execute stage. The register file writes in the first half of a cycle and reads in the second half, so a producer three instructions older never causes a hazard.

A static parameter selects one of four policies: no forwarding, forwarding only from EX/MEM, forwarding only from MEM/WB, or full forwarding. The stall output holds the PC and the IF/ID register and sends a bubble into execute. The operand-select codes are registered, so they travel into execute together with the instruction they belong to.

Top module: `fwd_stall_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both registered operand selects are 00.
- R2: A match is ignored when the older instruction does not write a register or when its destination is register 0. Such a match causes no stall and no forwarding.
- R3: When neither source matches a producer in the execute or memory stage, stall stays low and both selects become 00 (register file) on the next cycle. This gives one issue per cycle.
- R4: With full or EX/MEM-only forwarding, a source that matches an early producer in execute sees no stall. Its select becomes 10 (EX/MEM) on the next cycle.
- R5: With full forwarding, a source that matches a late producer in execute raises stall for exactly one cycle. On the following cycle, with the producer now in the memory stage, the select becomes 01 (MEM/WB).
- R6: With full or MEM/WB-only forwarding, a source that matches only the producer in the memory stage sees no stall. Its select becomes 01 (MEM/WB).
- R7: When a source matches both the execute-stage and the memory-stage producer, only the newer (execute-stage) producer is considered. Under full or EX/MEM-only forwarding its select becomes 10.
- R8: With EX/MEM-only forwarding, stall is raised for a match against a memory-stage producer, and for a match against a late producer in execute. A late producer therefore stalls its next consumer two cycles.
- R9: With MEM/WB-only forwarding, any match against the execute-stage producer raises stall. That producer is then reached through 01 on the following cycle.
- R10: With no forwarding, stall is raised for any match against either producer, and the selects are always 00.
- R11: The two sources are resolved independently in the same cycle. Under full forwarding, source A can take 10 while source B takes 01. Stall is raised if either source needs it.
- R12: In a cycle where stall is high, both selects become 00 on the next cycle (the bubble). The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | AW | First source register index of the decode instruction |
| src_b | input | AW | Second source register index of the decode instruction |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_we | input | 1 | Instruction in execute writes a register |
| ex_late | input | 1 | Result of the instruction in execute is ready only after the memory stage |
| mem_rd | input | AW | Destination of the instruction in the memory stage |
| mem_we | input | 1 | Instruction in the memory stage writes a register |
| stall | output | 1 | Hold PC and IF/ID, insert a bubble into execute |
| sel_a | output | 2 | Registered operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Registered operand B source, same encoding |

## Verification
The bench runs all four policies side by side on the same stimulus, so every case shows how the policies differ.

- **Load followed by its consumer.** The bench checks that the stall lasts one cycle under full forwarding and two under EX/MEM-only. A design that forwarded early would pass a stale value with select 10. A design that forgot the follow-up would return to 00 and read the register file too soon.
- **Both producers match one source.** This case catches a priority inversion, which would choose 01 and take the older value.
- **Mixed case.** Source A needs EX/MEM while source B needs MEM/WB. A design that merged the two decisions would give the wrong code on one operand.
- **Register 0 and non-writing producers.** These must cause no stall and no forwarding.
- **Stall cycles.** The bench checks that a stall cycle leaves 00 behind, so a bubble is never given a forwarding code.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FW_NONE       = 2'd0,
        FW_EXMEM_ONLY = 2'd1,
        FW_MEMWB_ONLY = 2'd2,
        FW_FULL       = 2'd3
    } fwd_policy_e;

    typedef enum logic [1:0] {
        OPND_RF  = 2'b00,
        OPND_MWB = 2'b01,
        OPND_EXM = 2'b10
    } opnd_sel_e;

    typedef struct packed {
        opnd_sel_e sel_a;
        opnd_sel_e sel_b;
    } fwd_state_t;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          we,
    output logic          hit
);
    // Register 0 and non-writing producers never create a dependence.
    always_comb begin
        hit = we && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
    import fwd_pkg::*;
#(
    parameter fwd_policy_e POLICY = FW_FULL
) (
    input  logic      hit_ex,
    input  logic      late_ex,
    input  logic      hit_mem,
    output opnd_sel_e sel,
    output logic      need_stall
);
    always_comb begin
        sel        = OPND_RF;
        need_stall = 1'b0;
        if (hit_ex) begin
            // Newest producer wins; the older match is irrelevant.
            unique case (POLICY)
                FW_FULL, FW_EXMEM_ONLY: begin
                    if (late_ex) need_stall = 1'b1;
                    else         sel        = OPND_EXM;
                end
                default: need_stall = 1'b1;
            endcase
        end else if (hit_mem) begin
            unique case (POLICY)
                FW_FULL, FW_MEMWB_ONLY: sel        = OPND_MWB;
                default:                need_stall = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import fwd_pkg::*;
#(
    parameter int          AW     = 5,
    parameter fwd_policy_e POLICY = FW_FULL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_late,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    output logic          stall,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b
);
    localparam int NSRC = 2;

    logic [AW-1:0] src_v [NSRC];
    logic          hit_ex_v  [NSRC];
    logic          hit_mem_v [NSRC];
    opnd_sel_e     sel_v     [NSRC];
    logic          stall_v   [NSRC];

    fwd_state_t st_d, st_q;

    assign src_v[0] = src_a;
    assign src_v[1] = src_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hz_match #(.AW(AW)) u_m_ex (
            .src (src_v[s]),
            .dst (ex_rd),
            .we  (ex_we),
            .hit (hit_ex_v[s])
        );
        hz_match #(.AW(AW)) u_m_mem (
            .src (src_v[s]),
            .dst (mem_rd),
            .we  (mem_we),
            .hit (hit_mem_v[s])
        );
        hz_resolve #(.POLICY(POLICY)) u_res (
            .hit_ex     (hit_ex_v[s]),
            .late_ex    (ex_late),
            .hit_mem    (hit_mem_v[s]),
            .sel        (sel_v[s]),
            .need_stall (stall_v[s])
        );
    end

    always_comb begin
        stall = stall_v[0] | stall_v[1];
        st_d  = st_q;
        if (stall) begin
            st_d.sel_a = OPND_RF;
            st_d.sel_b = OPND_RF;
        end else begin
            st_d.sel_a = sel_v[0];
            st_d.sel_b = sel_v[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel_a <= OPND_RF;
            st_q.sel_b <= OPND_RF;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_a = st_q.sel_a;
    assign sel_b = st_q.sel_b;

    // R12: the unused code never reaches the operand muxes
    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));

    // R12: a stall cycle leaves a bubble with register-file selects
    a_r12_bubble_rf: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (sel_a == 2'b00) && (sel_b == 2'b00));

    // R2: producers that write nothing or write register 0 never stall
    a_r2_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ex_we || ex_rd == '0) && (!mem_we || mem_rd == '0)) |-> !stall);

    if (POLICY == FW_NONE) begin : g_chk_none
        // R10: without forwarding only the register file feeds the ALU
        a_r10_rf_only: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_a == 2'b00) && (sel_b == 2'b00));
    end

    if (POLICY == FW_FULL) begin : g_chk_full
        // R5: a late producer directly ahead always costs a stall
        a_r5_late_stall: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_we && ex_late && ex_rd != '0 && ex_rd == src_a) |-> stall);
        // R4: an early producer directly ahead is taken from EX/MEM
        a_r4_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_we && !ex_late && ex_rd != '0 && ex_rd == src_a
             && !(ex_rd == src_b && ex_late)) |=> (sel_a == 2'b10));
    end
endmodule

// File: tb/fwd_stall_unit_test.sv
module fwd_stall_unit_test;
    import fwd_pkg::*;

    localparam int AW = 5;
    localparam int NP = 4; // index: 0 none, 1 EX/MEM only, 2 MEM/WB only, 3 full

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] src_a, src_b, ex_rd, mem_rd;
    logic ex_we, ex_late, mem_we;

    logic [NP-1:0] stall_v;
    logic [1:0]    sa_v [NP];
    logic [1:0]    sb_v [NP];

    for (genvar p = 0; p < NP; p++) begin : g_pol
        fwd_stall_unit #(.AW(AW), .POLICY(fwd_policy_e'(p))) uut (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_a   (src_a),
            .src_b   (src_b),
            .ex_rd   (ex_rd),
            .ex_we   (ex_we),
            .ex_late (ex_late),
            .mem_rd  (mem_rd),
            .mem_we  (mem_we),
            .stall   (stall_v[p]),
            .sel_a   (sa_v[p]),
            .sel_b   (sb_v[p])
        );
    end

    typedef struct {
        logic [7:0] sa;
        logic [7:0] sb;
        string      tag;
    } exp_t;

    exp_t scb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [7:0] pack_a();
        return {sa_v[3], sa_v[2], sa_v[1], sa_v[0]};
    endfunction
    function automatic logic [7:0] pack_b();
        return {sb_v[3], sb_v[2], sb_v[1], sb_v[0]};
    endfunction

    // Selects are packed {full, memwb, exmem, none}; stall bits likewise.
    task automatic step(input string tag,
                        input logic [AW-1:0] a, input logic [AW-1:0] b,
                        input logic [AW-1:0] erd, input logic ewe, input logic elate,
                        input logic [AW-1:0] mrd, input logic mwe,
                        input logic [3:0] exp_stall,
                        input logic [7:0] exp_sa, input logic [7:0] exp_sb);
        exp_t e;
        @(negedge clk);
        src_a = a; src_b = b;
        ex_rd = erd; ex_we = ewe; ex_late = elate;
        mem_rd = mrd; mem_we = mwe;
        #1;
        checks++;
        if (stall_v !== exp_stall) begin
            errors++;
            $display("FAIL %s stall: actual %b expected %b", tag, stall_v, exp_stall);
        end
        e.sa = exp_sa; e.sb = exp_sb; e.tag = tag;
        scb.push_back(e);
    endtask

    // Monitor: registered selects are compared after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                checks++;
                if (pack_a() !== e.sa || pack_b() !== e.sb) begin
                    errors++;
                    $display("FAIL %s selects: actual a=%b b=%b expected a=%b b=%b",
                             e.tag, pack_a(), pack_b(), e.sa, e.sb);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        src_a = '0; src_b = '0; ex_rd = '0; mem_rd = '0;
        ex_we = 1'b0; ex_late = 1'b0; mem_we = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (pack_a() !== 8'h00 || pack_b() !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset selects: actual a=%b b=%b expected 0", pack_a(), pack_b());
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        checks++;
        if (pack_a() !== 8'h00 || pack_b() !== 8'h00 || stall_v !== 4'b0000) begin
            errors++;
            $display("FAIL R1 after reset: actual a=%b b=%b st=%b expected 0",
                     pack_a(), pack_b(), stall_v);
        end

        step("R3 independent", 5'd1, 5'd2, 5'd3, 1, 0, 5'd4, 1, 4'b0000, 8'h00, 8'h00);
        step("R2 register0",   5'd0, 5'd0, 5'd0, 1, 0, 5'd0, 1, 4'b0000, 8'h00, 8'h00);
        step("R2 no write",    5'd5, 5'd6, 5'd5, 0, 0, 5'd6, 0, 4'b0000, 8'h00, 8'h00);
        // R4 / R9 / R10 / R12: early producer directly ahead on source A
        step("R4 early dist1", 5'd5, 5'd1, 5'd5, 1, 0, 5'd9, 1, 4'b0101,
             8'b10_00_10_00, 8'h00);
        // R5 / R8: late producer, then it sits in the memory stage
        step("R5 late dist1",  5'd7, 5'd1, 5'd7, 1, 1, 5'd9, 1, 4'b1111, 8'h00, 8'h00);
        step("R5 late follow", 5'd7, 5'd1, 5'd7, 0, 0, 5'd7, 1, 4'b0011,
             8'b01_01_00_00, 8'h00);
        step("R3 distance3",   5'd7, 5'd1, 5'd0, 0, 0, 5'd0, 0, 4'b0000, 8'h00, 8'h00);
        // R6 / R8 / R10: memory-stage producer on source B
        step("R6 dist2",       5'd2, 5'd8, 5'd3, 1, 0, 5'd8, 1, 4'b0011,
             8'h00, 8'b01_01_00_00);
        // R7: both producers write source A
        step("R7 priority",    5'd4, 5'd2, 5'd4, 1, 0, 5'd4, 1, 4'b0101,
             8'b10_00_10_00, 8'h00);
        // R11: A from EX/MEM, B from MEM/WB
        step("R11 mixed",      5'd4, 5'd6, 5'd4, 1, 0, 5'd6, 1, 4'b0111,
             8'b10_00_00_00, 8'b01_00_00_00);
        // R9: late producer under MEM/WB-only also stalls once
        step("R9 late dist1",  5'd9, 5'd9, 5'd9, 1, 1, 5'd0, 0, 4'b1111, 8'h00, 8'h00);
        step("R9 follow",      5'd9, 5'd9, 5'd0, 0, 0, 5'd9, 1, 4'b0011,
             8'b01_01_00_00, 8'b01_01_00_00);
        step("R12 idle",       5'd1, 5'd2, 5'd0, 0, 0, 5'd0, 0, 4'b0000, 8'h00, 8'h00);

        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule